// File: doc/BRIEF.md
# Expansion-Bus Memory Cycle Sequencer

This block masters memory cycles on a 16-bit expansion bus for a simple host port. The host offers a request for one cycle: read or write, byte or word, and whether the target is an 8-bit or a 16-bit device. The block then puts the address on the bus and holds it for one full clock with both strobes inactive. It asserts the active-low read or write strobe, times the command phase, and raises a one-clock done pulse when the transfer is complete.

Word requests to 16-bit devices use all sixteen data lanes in one bus cycle. An 8-bit device only listens on lanes 7..0, so a word request to such a device becomes two byte cycles at consecutive addresses, low byte first. For the second cycle the block moves the high byte down onto the low lanes. Without help from the device, the command phase lasts a fixed number of wait states. A device can end the command phase early by pulling the active-low zero-wait input.

Top module: `isa_mem_seq`

## Requirements
- R1: After reset, both strobes are high, data output enable and high-lane enable are low, and done and busy are low.
- R2: Before a strobe goes low, the bus address has stood unchanged for one full clock with both strobes high. The address stays unchanged for as long as the strobe is low.
- R3: A read (req_write=0) drives only bus_memr_n low and a write (req_write=1) drives only bus_memw_n low. The two strobes are never low together.
- R4: If bus_zws_n stays high, the command phase (strobe low) lasts WS16+1 clocks for a 16-bit target (req_dev8=0) and WS8+1 clocks for an 8-bit target (req_dev8=1). With the defaults this is 2 and 5 clocks.
- R5: When bus_zws_n is sampled low at the end of a command clock, the command phase ends after that clock, but never before the limit of R4 would end it. A 16-bit target can therefore finish in a single command clock.
- R6: For an 8-bit target, bus_zws_n is ignored in the first command clock, so the command phase lasts at least 2 clocks.
- R7: A word request (req_word=1) to an 8-bit target runs two bus cycles, at req_addr and then at req_addr+1. The first write cycle carries req_wdata[7:0] on lanes 7..0 and the second carries req_wdata[15:8] on lanes 7..0. bus_hi_en stays low in both.
- R8: On a word read from an 8-bit target, lanes 7..0 of the first cycle go to rd_data[7:0] and lanes 7..0 of the second cycle go to rd_data[15:8].
- R9: A word request to a 16-bit target (address even) runs one bus cycle with all 16 lanes and bus_hi_en high. rd_data is bus_d_in as sampled in the last command clock.
- R10: A byte request (req_word=0) to a 16-bit target uses lanes 7..0 with bus_hi_en low at an even address, and lanes 15..8 with bus_hi_en high at an odd address. The write byte is req_wdata[7:0] and the read byte comes back in rd_data[7:0] with rd_data[15:8]=0.
- R11: busy is high from the clock after a request is accepted until done has fallen. done is high for exactly one clock, the clock after the last strobe rises.
- R12: req_valid while busy is high is ignored: no further bus cycle starts and no memory location changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a request; taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_dev8 | input | 1 | 1 = target device is 8 bits wide |
| req_addr | input | AW | Byte address of the transfer |
| req_wdata | input | 16 | Write data (byte transfers use bits 7..0) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| bus_addr | output | AW | Address driven on the bus |
| bus_memr_n | output | 1 | Active-low memory read strobe |
| bus_memw_n | output | 1 | Active-low memory write strobe |
| bus_hi_en | output | 1 | High when lanes 15..8 carry valid data |
| bus_d_out | output | 16 | Data driven toward the bus |
| bus_d_oe | output | 1 | Enable for bus_d_out |
| bus_d_in | input | 16 | Data returned from the bus |
| bus_zws_n | input | 1 | Active-low zero-wait request from the device |

## Verification
The assertions take for granted that a word request to a 16-bit target has an even address and that req_dev8 matches the device that actually answers. The wait-cap and minimum-wait properties read the latched width class, so they only mean something under that agreement. The bench's device model holds the zero-wait line low only while a strobe is low, releases it between the two halves of a split transfer, and only issues word requests to 16-bit targets at even addresses. Requests made while busy are sent only to test R12.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_CMD  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;

  // Wait states granted when the device never asks for an early end.
  function automatic int unsigned wait_limit(input logic dev8,
                                             input int unsigned ws16,
                                             input int unsigned ws8);
    return dev8 ? ws8 : ws16;
  endfunction

  // True when lanes 15..8 carry the active data of this bus cycle.
  function automatic logic hi_lane(input logic word, input logic dev8,
                                   input logic a0);
    return !dev8 && (word || a0);
  endfunction

  // Places the host write data onto the bus lanes.
  function automatic logic [15:0] steer_out(input logic [15:0] wd,
                                            input logic word,
                                            input logic dev8,
                                            input logic a0,
                                            input logic second);
    logic [15:0] r;
    if (dev8)
      r = {8'h00, (second ? wd[15:8] : wd[7:0])};
    else if (word)
      r = wd;
    else if (a0)
      r = {wd[7:0], 8'h00};
    else
      r = {8'h00, wd[7:0]};
    return r;
  endfunction

  // Folds the lanes returned by one bus cycle into the host read result.
  function automatic logic [15:0] merge_rd(input logic [15:0] prev,
                                           input logic [15:0] din,
                                           input logic word,
                                           input logic dev8,
                                           input logic a0,
                                           input logic second);
    logic [15:0] r;
    if (dev8)
      r = second ? {din[7:0], prev[7:0]} : {8'h00, din[7:0]};
    else if (word)
      r = din;
    else if (a0)
      r = {8'h00, din[15:8]};
    else
      r = {8'h00, din[7:0]};
    return r;
  endfunction

endpackage

// File: rtl/isa_seq_wait_timer.sv
module isa_seq_wait_timer
  import isa_seq_pkg::*;
#(
  parameter int unsigned WS16 = 1,
  parameter int unsigned WS8  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic dev8,
  input  logic zws_n,
  output logic last_o
);
  localparam int unsigned MAXWS = (WS8 > WS16) ? WS8 : WS16;
  localparam int unsigned CW    = $clog2(MAXWS + 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          first_clk;
  logic          zws_hit;
  logic          lim_hit;

  always_comb begin
    lim       = CW'(wait_limit(dev8, WS16, WS8));
    first_clk = (cnt == '0);
    // an 8-bit device cannot shorten the first command clock
    zws_hit   = active && !zws_n && !(dev8 && first_clk);
    lim_hit   = active && (cnt == lim);
    last_o    = zws_hit || lim_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (active && !last_o)
      cnt <= cnt + 1'b1;
    else
      cnt <= '0;
  end

endmodule

// File: rtl/isa_seq_lanes.sv
module isa_seq_lanes
  import isa_seq_pkg::*;
(
  input  logic [15:0] wdata,
  input  logic [15:0] rd_prev,
  input  logic [15:0] din,
  input  logic        word,
  input  logic        dev8,
  input  logic        a0,
  input  logic        second,
  input  logic        drive,
  output logic [15:0] d_out,
  output logic        hi_en,
  output logic [15:0] rd_next
);
  always_comb begin
    d_out   = drive ? steer_out(wdata, word, dev8, a0, second) : 16'h0000;
    hi_en   = drive && hi_lane(word, dev8, a0);
    rd_next = merge_rd(rd_prev, din, word, dev8, a0, second);
  end
endmodule

// File: rtl/isa_seq_ctrl.sv
module isa_seq_ctrl
  import isa_seq_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic          req_dev8,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic          cmd_last,
  input  logic [15:0]   rd_next,
  output seq_state_t    state_o,
  output logic          wr_q,
  output logic          word_q,
  output logic          dev8_q,
  output logic          second_q,
  output logic [AW-1:0] cur_addr,
  output logic [15:0]   wdata_q,
  output logic [15:0]   rd_q
);
  seq_state_t    st;
  logic [AW-1:0] base_q;
  logic          accept;
  logic          split;

  assign accept   = (st == ST_IDLE) && req_valid;
  assign split    = word_q && dev8_q;
  assign cur_addr = base_q + AW'(second_q);
  assign state_o  = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      base_q   <= '0;
      wr_q     <= 1'b0;
      word_q   <= 1'b0;
      dev8_q   <= 1'b0;
      second_q <= 1'b0;
      wdata_q  <= '0;
      rd_q     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            base_q   <= req_addr;
            wr_q     <= req_write;
            word_q   <= req_word;
            dev8_q   <= req_dev8;
            wdata_q  <= req_wdata;
            second_q <= 1'b0;
            st       <= ST_ADDR;
          end
        end
        ST_ADDR: st <= ST_CMD;
        ST_CMD: begin
          if (cmd_last) begin
            if (!wr_q) rd_q <= rd_next;
            if (split && !second_q) begin
              second_q <= 1'b1;
              st       <= ST_ADDR;
            end else begin
              st <= ST_DONE;
            end
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/isa_mem_seq.sv
module isa_mem_seq
  import isa_seq_pkg::*;
#(
  parameter int unsigned AW   = 20,
  parameter int unsigned WS16 = 1,
  parameter int unsigned WS8  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic          req_dev8,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          busy,
  output logic          done,
  output logic [15:0]   rd_data,
  output logic [AW-1:0] bus_addr,
  output logic          bus_memr_n,
  output logic          bus_memw_n,
  output logic          bus_hi_en,
  output logic [15:0]   bus_d_out,
  output logic          bus_d_oe,
  input  logic [15:0]   bus_d_in,
  input  logic          bus_zws_n
);
  seq_state_t    st;
  logic          wr_q, word_q, dev8_q, second_q;
  logic [15:0]   wdata_q, rd_q, rd_next;
  logic [AW-1:0] cur_addr;
  logic          in_addr, in_cmd, cmd_last, drive;
  logic          tgt_dev8;   // named for the checker

  assign in_addr  = (st == ST_ADDR);
  assign in_cmd   = (st == ST_CMD);
  assign drive    = in_addr || in_cmd;
  assign tgt_dev8 = dev8_q;

  isa_seq_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
    .req_dev8(req_dev8), .req_addr(req_addr), .req_wdata(req_wdata),
    .cmd_last(cmd_last), .rd_next(rd_next),
    .state_o(st), .wr_q(wr_q), .word_q(word_q), .dev8_q(dev8_q),
    .second_q(second_q), .cur_addr(cur_addr), .wdata_q(wdata_q), .rd_q(rd_q)
  );

  isa_seq_wait_timer #(.WS16(WS16), .WS8(WS8)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(in_cmd), .dev8(dev8_q),
    .zws_n(bus_zws_n), .last_o(cmd_last)
  );

  isa_seq_lanes u_lanes (
    .wdata(wdata_q), .rd_prev(rd_q), .din(bus_d_in), .word(word_q),
    .dev8(dev8_q), .a0(cur_addr[0]), .second(second_q), .drive(drive),
    .d_out(bus_d_out), .hi_en(bus_hi_en), .rd_next(rd_next)
  );

  assign bus_addr   = cur_addr;
  assign bus_memr_n = !(in_cmd && !wr_q);
  assign bus_memw_n = !(in_cmd && wr_q);
  assign bus_d_oe   = drive && wr_q;
  assign busy       = (st != ST_IDLE);
  assign done       = (st == ST_DONE);
  assign rd_data    = rd_q;

endmodule

// File: rtl/isa_mem_seq_chk.sv
module isa_mem_seq_chk #(
  parameter int unsigned AW   = 20,
  parameter int unsigned WS16 = 1,
  parameter int unsigned WS8  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          memr_n,
  input logic          memw_n,
  input logic [AW-1:0] addr,
  input logic          done,
  input logic          busy,
  input logic          hi_en,
  input logic          tgt_dev8
);
  logic       low;
  logic [7:0] len;
  logic [7:0] lim;

  assign low = !memr_n || !memw_n;
  assign lim = tgt_dev8 ? 8'(WS8) : 8'(WS16);

  always_ff @(posedge clk) begin
    if (!rst_n)   len <= 8'd0;
    else if (low) len <= (len == 8'hFF) ? len : len + 8'd1;
    else          len <= 8'd0;
  end

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!memr_n && !memw_n));

  assert_addr_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(memr_n) || $fell(memw_n)) |-> ($stable(addr) && $past(memr_n) && $past(memw_n)));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (low && ($past(!memr_n) || $past(!memw_n))) |-> $stable(addr));

  assert_wait_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    low |-> (len <= lim));

  assert_min_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(memr_n) || $rose(memw_n)) && tgt_dev8) |-> (len >= 8'd2));

  assert_low_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tgt_dev8) |-> !hi_en);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

endmodule

bind isa_mem_seq isa_mem_seq_chk #(.AW(AW), .WS16(WS16), .WS8(WS8)) u_chk (
  .clk(clk), .rst_n(rst_n), .memr_n(bus_memr_n), .memw_n(bus_memw_n),
  .addr(bus_addr), .done(done), .busy(busy), .hi_en(bus_hi_en),
  .tgt_dev8(tgt_dev8)
);

// File: tb/sim_isa_mem_seq.sv
module sim_isa_mem_seq;
  localparam int AW = 20;
  localparam int WS16 = 1;
  localparam int WS8 = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_dev8 = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          busy, done, bus_memr_n, bus_memw_n, bus_hi_en, bus_d_oe;
  logic [15:0]   rd_data, bus_d_out, bus_d_in;
  logic [AW-1:0] bus_addr;
  logic          bus_zws_n = 1'b1;

  always #4 clk = ~clk;

  isa_mem_seq #(.AW(AW), .WS16(WS16), .WS8(WS8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_dev8(req_dev8), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n),
    .bus_hi_en(bus_hi_en), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
    .bus_d_in(bus_d_in), .bus_zws_n(bus_zws_n)
  );

  int n_chk = 0;
  int n_bad = 0;

  // device model state
  logic [7:0] mem [0:255];
  logic       dev_is8 = 1'b0;
  int         zdelay = 99;
  int         ncyc = 0;
  int         both_low = 0;
  int         c_len [0:63];
  int         c_addr [0:63];
  logic [15:0] c_dout [0:63];
  logic       c_hi [0:63];
  logic       c_wr [0:63];
  logic       c_setup [0:63];

  always_comb begin
    if (dev_is8) bus_d_in = {8'h00, mem[bus_addr[7:0]]};
    else         bus_d_in = {mem[{bus_addr[7:1], 1'b1}], mem[{bus_addr[7:1], 1'b0}]};
  end

  // Bus monitor and responder, sampling at the falling edge.
  initial begin
    int lowcnt;
    int p_addr;
    logic p_high;
    int ix;
    logic [7:0] a;
    lowcnt = 0; p_addr = 0; p_high = 1'b1;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    forever begin
      @(negedge clk);
      if (!bus_memr_n && !bus_memw_n) both_low++;
      if (!bus_memr_n || !bus_memw_n) begin
        ix = ncyc % 64;
        if (lowcnt == 0) begin
          c_addr[ix]  = int'(bus_addr);
          c_dout[ix]  = bus_d_out;
          c_hi[ix]    = bus_hi_en;
          c_wr[ix]    = !bus_memw_n;
          c_setup[ix] = (p_addr == int'(bus_addr)) && p_high;
        end
        lowcnt++;
        bus_zws_n = (lowcnt > zdelay) ? 1'b0 : 1'b1;
        p_high = 1'b0;
      end else begin
        if (lowcnt > 0) begin
          ix = ncyc % 64;
          c_len[ix] = lowcnt;
          a = c_addr[ix][7:0];
          if (c_wr[ix]) begin
            if (dev_is8) mem[a] = c_dout[ix][7:0];
            else begin
              if (!a[0]) mem[a] = c_dout[ix][7:0];
              if (c_hi[ix]) mem[a | 8'h01] = c_dout[ix][15:8];
            end
          end
          ncyc++;
        end
        lowcnt = 0;
        bus_zws_n = 1'b1;
        p_high = 1'b1;
      end
      p_addr = int'(bus_addr);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input logic dev8, input int zd);
    int l;
    l = zd + 1;
    if (dev8) begin
      if (l < 2) l = 2;
      if (l > WS8 + 1) l = WS8 + 1;
    end else if (l > WS16 + 1) l = WS16 + 1;
    return l;
  endfunction

  // Issues one request and waits for completion; inj sends a second request while busy.
  task automatic run(input logic wr, input logic word, input logic dev8,
                     input int addr, input logic [15:0] wd, input int zd,
                     input logic inj, output int base);
    bit seen;
    dev_is8 = dev8;
    zdelay  = zd;
    @(negedge clk);
    base = ncyc;
    req_write = wr; req_word = word; req_dev8 = dev8;
    req_addr = AW'(addr); req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 busy after accept", {31'd0, busy}, 32'd1);
    if (inj) begin
      req_write = 1'b1; req_word = 1'b0; req_dev8 = dev8;
      req_addr = AW'(8'h80); req_wdata = 16'h00C3; req_valid = 1'b1;
    end
    seen = 1'b0;
    for (int k = 0; k < 300 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    req_valid = 1'b0;
    chk("R11 done seen", {31'd0, seen}, 32'd1);
    @(negedge clk);
    chk("R11 done one clock", {31'd0, done}, 32'd0);
    chk("R11 busy cleared", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 memr_n", {31'd0, bus_memr_n}, 32'd1);
    chk("R1 memw_n", {31'd0, bus_memw_n}, 32'd1);
    chk("R1 done/busy", {30'd0, done, busy}, 32'd0);
    chk("R1 oe/hi", {30'd0, bus_d_oe, bus_hi_en}, 32'd0);
  endtask

  task automatic t_word16_write();
    int b;
    run(1'b1, 1'b1, 1'b0, 8'h10, 16'hBEEF, 99, 1'b0, b);
    chk("R9 one cycle", ncyc - b, 1);
    chk("R4 16-bit default length", c_len[b%64], exp_len(1'b0, 99));
    chk("R2 address setup", {31'd0, c_setup[b%64]}, 32'd1);
    chk("R3 write strobe", {31'd0, c_wr[b%64]}, 32'd1);
    chk("R9 lanes", {16'd0, c_dout[b%64]}, 32'hBEEF);
    chk("R9 hi_en", {31'd0, c_hi[b%64]}, 32'd1);
    chk("R9 memory", {16'd0, mem[8'h11], mem[8'h10]}, 32'hBEEF);
  endtask

  task automatic t_word16_read_fast();
    int b;
    logic [15:0] e;
    e = {mem[8'h21], mem[8'h20]};
    run(1'b0, 1'b1, 1'b0, 8'h20, 16'h0, 0, 1'b0, b);
    chk("R5 single command clock", c_len[b%64], 1);
    chk("R3 read strobe", {31'd0, c_wr[b%64]}, 32'd0);
    chk("R9 read data", {16'd0, rd_data}, {16'd0, e});
  endtask

  task automatic t_word8_write();
    int b;
    run(1'b1, 1'b1, 1'b1, 8'h31, 16'h1234, 99, 1'b0, b);
    chk("R7 two cycles", ncyc - b, 2);
    chk("R4 8-bit default length 1st", c_len[b%64], exp_len(1'b1, 99));
    chk("R4 8-bit default length 2nd", c_len[(b+1)%64], 5);
    chk("R7 first address", c_addr[b%64], 32'h31);
    chk("R7 second address", c_addr[(b+1)%64], 32'h32);
    chk("R2 setup second half", {31'd0, c_setup[(b+1)%64]}, 32'd1);
    chk("R7 first lanes", {16'd0, c_dout[b%64]}, 32'h0034);
    chk("R7 second lanes steered", {16'd0, c_dout[(b+1)%64]}, 32'h0012);
    chk("R7 hi_en low", {30'd0, c_hi[b%64], c_hi[(b+1)%64]}, 32'd0);
    chk("R7 memory", {16'd0, mem[8'h32], mem[8'h31]}, 32'h1234);
  endtask

  task automatic t_word8_read();
    int b;
    logic [15:0] e;
    e = {mem[8'h41], mem[8'h40]};
    run(1'b0, 1'b1, 1'b1, 8'h40, 16'h0, 0, 1'b0, b);
    chk("R6 zws ignored first clock a", c_len[b%64], exp_len(1'b1, 0));
    chk("R6 zws ignored first clock b", c_len[(b+1)%64], 2);
    chk("R8 assembled read", {16'd0, rd_data}, {16'd0, e});
  endtask

  task automatic t_byte8_mid_zws();
    int b;
    run(1'b1, 1'b0, 1'b1, 8'h48, 16'hFF77, 2, 1'b0, b);
    chk("R5 8-bit early end", c_len[b%64], 3);
    chk("R10 8-bit byte lanes", {15'd0, c_hi[b%64], c_dout[b%64]}, 32'h0077);
    chk("R10 8-bit byte memory", {24'd0, mem[8'h48]}, 32'h77);
  endtask

  task automatic t_byte16();
    int b;
    logic [7:0] keep, e0, e1;
    keep = mem[8'h50];
    run(1'b1, 1'b0, 1'b0, 8'h51, 16'hEEA5, 99, 1'b0, b);
    chk("R10 odd write hi lanes", {15'd0, c_hi[b%64], c_dout[b%64]}, 32'h1A500);
    chk("R10 odd write memory", {16'd0, mem[8'h51], mem[8'h50]}, {16'd0, 8'hA5, keep});
    keep = mem[8'h53];
    run(1'b1, 1'b0, 1'b0, 8'h52, 16'hEE3C, 99, 1'b0, b);
    chk("R10 even write lo lanes", {15'd0, c_hi[b%64], c_dout[b%64]}, 32'h0003C);
    chk("R10 even write memory", {16'd0, mem[8'h53], mem[8'h52]}, {16'd0, keep, 8'h3C});
    e0 = mem[8'h60];
    e1 = mem[8'h61];
    run(1'b0, 1'b0, 1'b0, 8'h60, 16'h0, 99, 1'b0, b);
    chk("R10 even byte read", {16'd0, rd_data}, {24'd0, e0});
    run(1'b0, 1'b0, 1'b0, 8'h61, 16'h0, 99, 1'b0, b);
    chk("R10 odd byte read", {16'd0, rd_data}, {24'd0, e1});
    chk("R10 odd read hi_en", {31'd0, c_hi[b%64]}, 32'd1);
  endtask

  task automatic t_busy_ignore();
    int b;
    logic [7:0] keep;
    keep = mem[8'h80];
    run(1'b1, 1'b1, 1'b0, 8'h70, 16'h4321, 99, 1'b1, b);
    repeat (4) @(negedge clk);
    chk("R12 no extra cycle", ncyc - b, 1);
    chk("R12 memory untouched", {24'd0, mem[8'h80]}, {24'd0, keep});
    chk("R12 first request intact", {16'd0, mem[8'h71], mem[8'h70]}, 32'h4321);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word16_write();
    t_word16_read_fast();
    t_word8_write();
    t_word8_read();
    t_byte8_mid_zws();
    t_byte16();
    t_busy_ignore();
    chk("R3 strobes never both low", both_low, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule